// File: doc/BRIEF.md
# Timer Input Capture and Output Compare

A free-running 16-bit counter feeds two channels that software reaches through an 8-bit register bus. The capture channel watches an external pin. On the active edge it copies the counter into a high and a low capture byte and raises a capture flag. The compare channel holds a 16-bit target in two bytes. When the counter equals the target, it drives a programmed level onto the compare pin and raises a compare flag. An interrupt request combines the two flags, each gated by its own enable bit.

Because 16-bit values cross an 8-bit bus in two halves, the block applies byte-order interlocks:
- Reading the upper capture byte freezes the capture pair until the lower byte is read.
- Writing the upper compare byte suspends matching until the lower byte arrives.
- A flag clears only when the status register is read while that flag is set, and is followed by an access to the flag's lower byte.

The bus is a plain register port: one access per cycle, no wait states. Read data is combinational from the address. The side effects of a read, a write or a status read take place at the clock edge that ends the access cycle.

Top module: `tcc_top`

## Requirements
- R1: After reset the counter starts at 0, advances by one on every clock and wraps modulo 2^16.
- R2: Control bit 0 selects the capture edge (1 = rising, 0 = falling). `cap_in` passes through a two-flop synchronizer and an edge detector. The capture bytes then take the counter value present in the cycle before the third clock edge after the pin change. The opposite edge captures nothing.
- R3: A read of the capture high byte (0x14) blocks all captures until the capture low byte (0x15) is read.
- R4: Bus writes to 0x14 or 0x15 change neither capture byte.
- R5: A capture sets status bit 7. The bit clears only on a read of 0x15 that follows a status (0x13) read made while bit 7 was already set.
- R6: The compare can match only while it is enabled (see R7). When the counter equals {0x16, 0x17}, `cmp_out` takes control bit 1 at that clock edge and status bit 6 is set. The pin keeps that level until the next match.
- R7: A write to 0x16 disables matching until 0x17 is written. Matching is also disabled after reset until the first write to 0x17.
- R8: Status bit 6 clears on a read or a write of 0x17 that follows a status read made while bit 6 was set. Without that status read, the access leaves the flag set.
- R9: If a flag's set event and its armed clear access fall in the same cycle, the flag stays set.
- R10: `irq` = (bit 7 AND control bit 7) OR (bit 6 AND control bit 6).
- R11: Reset clears the control register (0x12), both flags and `cmp_out`, and deasserts `irq`. The four capture and compare bytes are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_in | input | 1 | Asynchronous capture pin |
| cmp_out | output | 1 | Compare output pin |
| irq | output | 1 | Interrupt request |
| bus_addr | input | 5 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |

## Verification
A flag's set event and its armed clearing access can share one clock edge. For capture, the bench arms the flag with a status read and then starts a capture edge. It places the 0x15 read exactly in the cycle before the edge that latches the counter. For compare, it places a 0x17 read on the cycle in which the counter equals the target. In both cases, the bench requires the flag (seen in status or on `irq`) to stay set, and the captured bytes to show the newer count.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int ADR_CTRL = 'h12;
  localparam int ADR_STAT = 'h13;
  localparam int ADR_ICH  = 'h14;
  localparam int ADR_ICL  = 'h15;
  localparam int ADR_OCH  = 'h16;
  localparam int ADR_OCL  = 'h17;

  localparam int ST_ICF = 7;
  localparam int ST_OCF = 6;

  typedef struct packed {
    logic icie;
    logic ocie;
    logic lvl;
    logic rise;
  } ctrl_t;
endpackage

// File: rtl/tcc_counter.sv
module tcc_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> cnt == W'($past(cnt) + 1'b1));
endmodule

// File: rtl/tcc_capture.sv
module tcc_capture #(
  parameter int W     = 16,
  parameter int SYNC  = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pin,
  input  logic         rise_sel,
  input  logic [W-1:0] cnt,
  input  logic         rd_hi,
  input  logic         rd_lo,
  input  logic         stat_rd,
  output logic [W-1:0] icr,
  output logic         flag
);
  logic [SYNC-1:0] sync_q;
  logic            prev_q;
  logic            lock_q;
  logic            arm_q;
  logic            edge_hit;
  logic            take;
  logic            s_now;

  generate
    if (SYNC == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC-2:0], pin};
      end
    end
  endgenerate

  assign s_now    = sync_q[SYNC-1];
  assign edge_hit = rise_sel ? (s_now & ~prev_q) : (~s_now & prev_q);
  assign take     = edge_hit & ~lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      prev_q <= s_now;
      if (rd_lo)      lock_q <= 1'b0;
      else if (rd_hi) lock_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take) icr <= cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      if (stat_rd)            arm_q <= flag;
      else if (rd_lo)         arm_q <= 1'b0;
      if (take)               flag <= 1'b1;
      else if (rd_lo && arm_q) flag <= 1'b0;
    end
  end

  p_lock_freezes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(icr));
  p_flag_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lo && arm_q && !take) |=> !flag);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && rd_lo) |=> flag);
endmodule

// File: rtl/tcc_compare.sv
module tcc_compare #(
  parameter int BW = 8,
  parameter int W  = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  cnt,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic          acc_lo,
  input  logic          stat_rd,
  input  logic [BW-1:0] wdata,
  input  logic          lvl,
  output logic [W-1:0]  ocr,
  output logic          flag,
  output logic          pin
);
  logic cmp_en;
  logic arm_q;
  logic hit;

  always_ff @(posedge clk) begin
    if (wr_hi) ocr[W-1:BW] <= wdata;
    if (wr_lo) ocr[BW-1:0] <= wdata;
  end

  assign hit = cmp_en && (cnt == ocr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_en <= 1'b0;
      pin    <= 1'b0;
      flag   <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (wr_hi)      cmp_en <= 1'b0;
      else if (wr_lo) cmp_en <= 1'b1;
      if (hit) pin <= lvl;
      if (stat_rd)     arm_q <= flag;
      else if (acc_lo) arm_q <= 1'b0;
      if (hit)                  flag <= 1'b1;
      else if (acc_lo && arm_q) flag <= 1'b0;
    end
  end

  p_pin_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> pin == $past(lvl));
  p_hold_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en |=> $stable(pin) && !$rose(flag));
  p_ocf_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_lo && arm_q && !hit) |=> !flag);
endmodule

// File: rtl/tcc_top.sv
module tcc_top
  import tcc_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_in,
  output logic              cmp_out,
  output logic              irq,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata
);
  localparam int CNT_W = 2 * BYTE_W;

  ctrl_t             ctrl;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  icr;
  logic [CNT_W-1:0]  ocr;
  logic              icf, ocf;
  logic sel_ctrl, sel_stat, sel_ich, sel_icl, sel_och, sel_ocl;

  assign sel_ctrl = bus_addr == ADDR_W'(ADR_CTRL);
  assign sel_stat = bus_addr == ADDR_W'(ADR_STAT);
  assign sel_ich  = bus_addr == ADDR_W'(ADR_ICH);
  assign sel_icl  = bus_addr == ADDR_W'(ADR_ICL);
  assign sel_och  = bus_addr == ADDR_W'(ADR_OCH);
  assign sel_ocl  = bus_addr == ADDR_W'(ADR_OCL);

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl <= '0;
    else if (bus_wr && sel_ctrl)
      ctrl <= '{icie: bus_wdata[7], ocie: bus_wdata[6],
                lvl: bus_wdata[1], rise: bus_wdata[0]};
  end

  tcc_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt(cnt)
  );

  tcc_capture #(.W(CNT_W), .SYNC(SYNC_STAGES)) u_cap (
    .clk(clk), .rst_n(rst_n), .pin(cap_in), .rise_sel(ctrl.rise),
    .cnt(cnt), .rd_hi(bus_rd && sel_ich), .rd_lo(bus_rd && sel_icl),
    .stat_rd(bus_rd && sel_stat), .icr(icr), .flag(icf)
  );

  tcc_compare #(.BW(BYTE_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cnt(cnt),
    .wr_hi(bus_wr && sel_och), .wr_lo(bus_wr && sel_ocl),
    .acc_lo((bus_wr || bus_rd) && sel_ocl),
    .stat_rd(bus_rd && sel_stat), .wdata(bus_wdata), .lvl(ctrl.lvl),
    .ocr(ocr), .flag(ocf), .pin(cmp_out)
  );

  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl) begin
      bus_rdata[7] = ctrl.icie;
      bus_rdata[6] = ctrl.ocie;
      bus_rdata[1] = ctrl.lvl;
      bus_rdata[0] = ctrl.rise;
    end
    if (sel_stat) begin
      bus_rdata[ST_ICF] = icf;
      bus_rdata[ST_OCF] = ocf;
    end
    if (sel_ich) bus_rdata = icr[CNT_W-1:BYTE_W];
    if (sel_icl) bus_rdata = icr[BYTE_W-1:0];
    if (sel_och) bus_rdata = ocr[CNT_W-1:BYTE_W];
    if (sel_ocl) bus_rdata = ocr[BYTE_W-1:0];
  end

  assign irq = (icf && ctrl.icie) || (ocf && ctrl.ocie);

  p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (icf || ocf));
  p_reset_quiet_r11: assert property (@(posedge clk)
    !rst_n |=> !icf && !ocf && !cmp_out);
endmodule

// File: tb/tcc_top_test.sv
module tcc_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cap_in = 1'b0;
  logic       cmp_out, irq;
  logic [4:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [15:0] bc;
  int vecs = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tcc_top uut (
    .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .cmp_out(cmp_out), .irq(irq),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) bc <= '0;
    else        bc <= bc + 1'b1;
  end

  function automatic logic cap_expected(input logic rise, input logic old_l, input logic new_l);
    return rise ? (!old_l && new_l) : (old_l && !new_l);
  endfunction

  function automatic logic [7:0] ctrl_byte(input logic icie, input logic ocie,
                                          input logic lvl, input logic rise);
    return {icie, ocie, 4'b0, lvl, rise};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = 5'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = 5'(a); bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic drive_cap(input logic lv, output logic [15:0] seen);
    @(negedge clk);
    cap_in = lv;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    seen = bc;
  endtask

  task automatic wait_cnt(input logic [15:0] v);
    while (bc != v) @(negedge clk);
  endtask

  task automatic set_ocr(input logic [15:0] t);
    wr('h16, t[15:8]);
    wr('h17, t[7:0]);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [15:0] e, e2, t;
    logic cur;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    chk(cmp_out == 0, "R11 cmp_out", cmp_out, 0);
    chk(irq == 0, "R11 irq", irq, 0);
    rd('h12, d); chk(d == 8'h00, "R11 ctrl", d, 0);
    rd('h13, d); chk(d == 8'h00, "R11 status", d, 0);

    // R2 rising capture, R1 counter value, R5 clear
    wr('h12, ctrl_byte(0, 0, 0, 1));
    drive_cap(1, e);
    rd('h13, d); chk(d == 8'h80, "R5 icf set", d, 8'h80);
    rd('h14, d); chk(d == e[15:8], "R2 icr hi", d, e[15:8]);
    rd('h15, d); chk(d == e[7:0], "R1 icr lo count", d, e[7:0]);
    rd('h13, d); chk(d == 8'h00, "R5 icf cleared", d, 0);

    // R2 opposite edge ignored
    drive_cap(0, e2);
    rd('h13, d); chk(d == 8'h00, "R2 falling ignored", d, 0);
    wr('h12, ctrl_byte(0, 0, 0, 0));
    drive_cap(1, e2);
    rd('h13, d); chk(d == 8'h00, "R2 rising ignored", d, 0);
    drive_cap(0, e);
    rd('h13, d); chk(d == 8'h80, "R2 falling capture", d, 8'h80);

    // R3 lock after high byte read
    rd('h14, d); chk(d == e[15:8], "R3 hi before lock", d, e[15:8]);
    drive_cap(1, e2);
    drive_cap(0, e2);
    rd('h15, d); chk(d == e[7:0], "R3 lo frozen", d, e[7:0]);
    rd('h14, d); chk(d == e[15:8], "R3 hi frozen", d, e[15:8]);
    rd('h15, d);
    rd('h13, d); chk(d == 8'h00, "R3 blocked edge no flag", d, 0);

    // R4 writes to capture bytes ignored
    wr('h14, 8'h5A); wr('h15, 8'hA5);
    rd('h14, d); chk(d == e[15:8], "R4 hi unchanged", d, e[15:8]);
    rd('h15, d); chk(d == e[7:0], "R4 lo unchanged", d, e[7:0]);

    // R5 no clear without status read
    drive_cap(1, e2);
    drive_cap(0, e);
    rd('h15, d);
    rd('h13, d); chk(d == 8'h80, "R5 unarmed read keeps flag", d, 8'h80);
    rd('h15, d);
    rd('h13, d); chk(d == 8'h00, "R5 armed read clears", d, 0);
    drive_cap(1, e2);
    drive_cap(0, e);
    rd('h15, d);
    rd('h13, d); chk(d == 8'h80, "R5 stale status read does not arm", d, 8'h80);
    rd('h15, d);

    // R9 capture set and armed clear in one cycle
    drive_cap(1, e2);
    drive_cap(0, e);
    rd('h13, d);
    drive_cap(1, e2);
    drive_cap(0, e);
    bus_addr = 5'h15; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    rd('h13, d); chk(d == 8'h80, "R9 capture wins", d, 8'h80);
    rd('h14, d); chk(d == e[15:8], "R9 new capture hi", d, e[15:8]);
    rd('h15, d); chk(d == e[7:0], "R9 new capture lo", d, e[7:0]);
    rd('h13, d); chk(d == 8'h00, "R5 cleared after R9", d, 0);

    // R6 compare match drives level 1
    wr('h12, ctrl_byte(0, 0, 1, 0));
    t = bc + 16'd40;
    set_ocr(t);
    wait_cnt(t);
    chk(cmp_out == 0, "R6 pin before match", cmp_out, 0);
    @(negedge clk);
    chk(cmp_out == 1, "R6 pin at match", cmp_out, 1);
    chk(irq == 0, "R10 irq masked", irq, 0);
    wr('h12, ctrl_byte(0, 1, 1, 0));
    chk(irq == 1, "R10 irq ocf", irq, 1);

    // R8 unarmed write does not clear; R9 compare set wins
    t = bc + 16'd40;
    set_ocr(t);
    chk(irq == 1, "R8 unarmed write keeps ocf", irq, 1);
    rd('h13, d); chk(d == 8'h40, "R6 ocf status", d, 8'h40);
    wait_cnt(t);
    bus_addr = 5'h17; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(irq == 1, "R9 match wins", irq, 1);
    rd('h13, d); chk(d == 8'h40, "R9 ocf kept", d, 8'h40);
    rd('h17, d);
    chk(irq == 0, "R8 read clears ocf", irq, 0);

    // R6 level 0 held; R8 write clear
    wr('h12, ctrl_byte(0, 1, 0, 0));
    t = bc + 16'd40;
    set_ocr(t);
    wait_cnt(t + 16'd1);
    chk(cmp_out == 0, "R6 pin to level 0", cmp_out, 0);
    chk(irq == 1, "R10 irq at match", irq, 1);
    rd('h13, d);
    wr('h17, t[7:0]);
    chk(irq == 0, "R8 write clears ocf", irq, 0);

    // R7 upper write suspends compare
    wr('h12, ctrl_byte(0, 1, 1, 0));
    t = bc + 16'd300;
    set_ocr(t);
    wr('h16, t[15:8]);
    wait_cnt(t + 16'd5);
    chk(cmp_out == 0, "R7 no match while suspended", cmp_out, 0);
    chk(irq == 0, "R7 no flag while suspended", irq, 0);
    t = bc + 16'd40;
    set_ocr(t);
    wait_cnt(t + 16'd1);
    chk(cmp_out == 1, "R7 resumes after low write", cmp_out, 1);
    rd('h13, d); rd('h17, d);

    // random mix
    cur = cap_in;
    for (int i = 0; i < 40; i++) begin
      logic rise, lvl, nl, exp_cap;
      int off;
      rise = 1'($urandom);
      lvl  = 1'($urandom);
      wr('h12, ctrl_byte(0, 0, lvl, rise));
      nl = ~cur;
      exp_cap = cap_expected(rise, cur, nl);
      drive_cap(nl, e);
      cur = nl;
      rd('h13, d);
      chk(d[7] == exp_cap, "R2 random edge", d[7], exp_cap);
      if (exp_cap) begin
        rd('h14, d); chk(d == e[15:8], "R2 random hi", d, e[15:8]);
        rd('h15, d); chk(d == e[7:0], "R1 random lo", d, e[7:0]);
      end
      off = 10 + int'($urandom % 60);
      t = bc + 16'(off);
      set_ocr(t);
      wait_cnt(t + 16'd1);
      chk(cmp_out == lvl, "R6 random level", cmp_out, lvl);
      rd('h13, d); chk(d == 8'h40, "R8 random status", d, 8'h40);
      rd('h17, d);
      rd('h13, d); chk(d == 8'h00, "R8 random clear", d, 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule